// File: doc/BRIEF.md
# ALU Operand and Result Manager

This block brackets one ALU operation from issue to write-back. An issue strobe hands it an opcode, operand-modifier flags and a per-port read mask. The block samples all of them on that cycle and raises busy on the next. It then asks the register file for each operand it still needs through a per-port release/go handshake and forwards every granted operand to the ALU in the cycle it arrives. Once the ALU has a result, the block asks for a write with a second release/go pair. Busy stays high until that write is granted.

Operand A can be forced to zero, inverted, or both. Operand B can be replaced by an immediate. A port that is zeroed, replaced or masked never raises its read release. For verification the top contains a small behavioural ALU. It adds over a parameterised number of cycles and subtracts with no delay for every other opcode. Only one operation is in flight at a time.

Top module: `alu_opnd_mgr`

## Requirements
- R1: During and directly after reset, busy_o, every rd_rel_o bit and wr_rel_o are 0.
- R2: busy_o is 0 on the cycle issue_i is accepted and 1 on the following cycle. It never rises unless issue_i was high on the cycle before.
- R3: For each required port, rd_rel_o rises on the cycle after issue. It stays high for any number of cycles until rd_go_i for that port is seen.
- R4: rd_go_i may be asserted in the first cycle its release is visible. While go and release are both high, alu_opnd_o for that port shows the operand on src_i, after modifiers, in the same cycle.
- R5: A port's release falls on the cycle after its go. It stays low for the rest of that busy period.
- R6: With imm_ok_i set at issue, operand B (port 1) equals imm_i and rd_rel_o[1] never rises.
- R7: With zero_a_i set at issue, operand A (port 0) is zero before inversion and rd_rel_o[0] never rises.
- R8: A set bit of rd_mask_i suppresses that port's release, and its operand reads as zero. rd_mask_i bit i belongs to port i.
- R9: With inv_a_i set, operand A is bitwise inverted after any zeroing. For example, add of inverted 5 and 2 gives 65532 and zero plus invert gives 16'hFFFF.
- R10: After the result is ready, wr_rel_o is high and result_o stays stable until wr_go_i. busy_o is 0 on the cycle after the write go, within 50 cycles of issue.
- R11: Opcode, flags and immediate are used only as sampled at issue. Changing them afterwards has no effect.
- R12: Opcode 1 produces A+B modulo 2^16. Any other opcode produces A-B modulo 2^16.
- R13: An issue_i pulse while busy_o is high is ignored: the running operation and its result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Issue strobe, accepted only while idle |
| op_i | input | OP_W | Opcode |
| inv_a_i | input | 1 | Invert operand A |
| zero_a_i | input | 1 | Force operand A to zero, no read |
| imm_ok_i | input | 1 | Use immediate as operand B, no read |
| imm_i | input | DATA_W | Immediate value |
| rd_mask_i | input | N_SRC | Per-port read suppress, held while busy |
| rd_rel_o | output | N_SRC | Per-port read request |
| rd_go_i | input | N_SRC | Per-port read grant |
| src_i | input | N_SRC x DATA_W | Per-port operand data, valid with go |
| alu_opnd_o | output | N_SRC x DATA_W | Operands as presented to the ALU |
| busy_o | output | 1 | Operation in progress |
| wr_rel_o | output | 1 | Result write request |
| wr_go_i | input | 1 | Result write grant |
| result_o | output | DATA_W | Result, held while wr_rel_o is high |

## Verification
The bound checker watches the handshake rules on every cycle:
- busy rises only after an issue, and busy is up after an accepted issue;
- a release holds while its go is absent, drops after its go, and never comes back in the same busy period;
- the write release and result hold until the write go, and busy drops after it.

The bench scenarios are needed for the values. They cover the arithmetic under each modifier combination, which ports are suppressed by immediate, zero or mask, the operand shown on the same-cycle go, and that late changes to issue-time inputs or an extra issue pulse leave the result untouched.

// File: rtl/alu_mgr_pkg.sv
package alu_mgr_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_READ  = 2'd1,
      PH_EXEC  = 2'd2,
      PH_WRITE = 2'd3
   } mgr_phase_t;

   typedef struct packed {
      logic inv_a;
      logic zero_a;
      logic imm_ok;
   } opnd_mod_t;

endpackage

// File: rtl/mgr_rd_port.sv
module mgr_rd_port #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_i,
   input  logic              need_i,
   input  logic              go_i,
   input  logic [DATA_W-1:0] src_i,
   output logic              rel_o,
   output logic [DATA_W-1:0] raw_o
);
   logic              pend_q;
   logic [DATA_W-1:0] val_q;
   logic              fire;

   assign fire  = pend_q & go_i;
   assign rel_o = pend_q;
   assign raw_o = fire ? src_i : val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         val_q  <= '0;
      end else if (accept_i) begin
         pend_q <= need_i;
         val_q  <= '0;
      end else if (fire) begin
         pend_q <= 1'b0;
         val_q  <= src_i;
      end
   end
endmodule

// File: rtl/mgr_wr_port.sv
module mgr_wr_port #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_i,
   input  logic [DATA_W-1:0] res_i,
   input  logic              go_i,
   output logic              rel_o,
   output logic              done_o,
   output logic [DATA_W-1:0] res_o
);
   logic              rel_q;
   logic [DATA_W-1:0] res_q;

   assign rel_o  = rel_q;
   assign done_o = rel_q & go_i;
   assign res_o  = res_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rel_q <= 1'b0;
         res_q <= '0;
      end else if (cap_i) begin
         rel_q <= 1'b1;
         res_q <= res_i;
      end else if (done_o) begin
         rel_q <= 1'b0;
      end
   end
endmodule

// File: rtl/mgr_alu_model.sv
module mgr_alu_model #(
   parameter int DATA_W  = 16,
   parameter int OP_W    = 4,
   parameter int OPC_ADD = 1,
   parameter int ADD_LAT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [OP_W-1:0]   op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic              valid_o,
   output logic [DATA_W-1:0] res_o
);
   logic is_add;
   assign is_add = (op_i == OPC_ADD[OP_W-1:0]);

   generate
      if (ADD_LAT == 0) begin : g_comb_add
         assign valid_o = start_i;
         assign res_o   = is_add ? (a_i + b_i) : (a_i - b_i);
      end else begin : g_seq_add
         localparam int CW = $clog2(ADD_LAT + 1);
         logic [CW-1:0]     cnt_q;
         logic [DATA_W-1:0] sum_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               sum_q <= '0;
            end else if (start_i && is_add) begin
               cnt_q <= CW'(ADD_LAT);
               sum_q <= a_i + b_i;
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end

         assign valid_o = (start_i && !is_add) || (cnt_q == CW'(1));
         assign res_o   = (cnt_q != '0) ? sum_q : (a_i - b_i);
      end
   endgenerate
endmodule

// File: rtl/alu_opnd_mgr.sv
module alu_opnd_mgr
   import alu_mgr_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int OP_W    = 4,
   parameter int N_SRC   = 2,
   parameter int OPC_ADD = 1,
   parameter int ADD_LAT = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          issue_i,
   input  logic [OP_W-1:0]               op_i,
   input  logic                          inv_a_i,
   input  logic                          zero_a_i,
   input  logic                          imm_ok_i,
   input  logic [DATA_W-1:0]             imm_i,
   input  logic [N_SRC-1:0]              rd_mask_i,
   output logic [N_SRC-1:0]              rd_rel_o,
   input  logic [N_SRC-1:0]              rd_go_i,
   input  logic [N_SRC-1:0][DATA_W-1:0]  src_i,
   output logic [N_SRC-1:0][DATA_W-1:0]  alu_opnd_o,
   output logic                          busy_o,
   output logic                          wr_rel_o,
   input  logic                          wr_go_i,
   output logic [DATA_W-1:0]             result_o
);
   localparam int PORT_A = 0;
   localparam int PORT_B = 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("alu_opnd_mgr: DATA_W must be at least 2");
   end
   if (N_SRC < 2) begin : g_bad_ports
      $error("alu_opnd_mgr: N_SRC must be at least 2");
   end
   if (OPC_ADD >= (1 << OP_W)) begin : g_bad_opc
      $error("alu_opnd_mgr: OPC_ADD does not fit OP_W");
   end

   mgr_phase_t              phase_q, phase_d;
   opnd_mod_t               mod_q;
   logic [OP_W-1:0]         op_q;
   logic [DATA_W-1:0]       imm_q;
   logic                    accept;
   logic [N_SRC-1:0]        need;
   logic [N_SRC-1:0]        pend;
   logic [N_SRC-1:0][DATA_W-1:0] raw;
   logic                    all_read;
   logic                    alu_start;
   logic                    alu_valid;
   logic [DATA_W-1:0]       alu_res;
   logic                    cap;
   logic                    wr_done;

   assign accept   = issue_i && (phase_q == PH_IDLE);
   assign busy_o   = (phase_q != PH_IDLE);
   assign rd_rel_o = pend;
   assign all_read = (pend == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mod_q <= '0;
         op_q  <= '0;
         imm_q <= '0;
      end else if (accept) begin
         mod_q <= '{inv_a: inv_a_i, zero_a: zero_a_i, imm_ok: imm_ok_i};
         op_q  <= op_i;
         imm_q <= imm_i;
      end
   end

   for (genvar gi = 0; gi < N_SRC; gi++) begin : g_port
      if (gi == PORT_A) begin : g_need_a
         assign need[gi] = !(rd_mask_i[gi] || zero_a_i);
         logic [DATA_W-1:0] zeroed;
         assign zeroed         = mod_q.zero_a ? '0 : raw[gi];
         assign alu_opnd_o[gi] = mod_q.inv_a ? ~zeroed : zeroed;
      end else if (gi == PORT_B) begin : g_need_b
         assign need[gi]       = !(rd_mask_i[gi] || imm_ok_i);
         assign alu_opnd_o[gi] = mod_q.imm_ok ? imm_q : raw[gi];
      end else begin : g_need_x
         assign need[gi]       = !rd_mask_i[gi];
         assign alu_opnd_o[gi] = raw[gi];
      end

      mgr_rd_port #(.DATA_W(DATA_W)) u_rd (
         .clk      (clk),
         .rst_n    (rst_n),
         .accept_i (accept),
         .need_i   (need[gi]),
         .go_i     (rd_go_i[gi]),
         .src_i    (src_i[gi]),
         .rel_o    (pend[gi]),
         .raw_o    (raw[gi])
      );
   end

   assign alu_start = (phase_q == PH_READ) && all_read;
   assign cap       = ((phase_q == PH_READ) && all_read && alu_valid)
                   || ((phase_q == PH_EXEC) && alu_valid);

   mgr_alu_model #(
      .DATA_W  (DATA_W),
      .OP_W    (OP_W),
      .OPC_ADD (OPC_ADD),
      .ADD_LAT (ADD_LAT)
   ) u_alu (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (alu_start),
      .op_i    (op_q),
      .a_i     (alu_opnd_o[PORT_A]),
      .b_i     (alu_opnd_o[PORT_B]),
      .valid_o (alu_valid),
      .res_o   (alu_res)
   );

   mgr_wr_port #(.DATA_W(DATA_W)) u_wr (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_i  (cap),
      .res_i  (alu_res),
      .go_i   (wr_go_i),
      .rel_o  (wr_rel_o),
      .done_o (wr_done),
      .res_o  (result_o)
   );

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE:  if (accept) phase_d = PH_READ;
         PH_READ:  if (all_read) phase_d = alu_valid ? PH_WRITE : PH_EXEC;
         PH_EXEC:  if (alu_valid) phase_d = PH_WRITE;
         PH_WRITE: if (wr_done) phase_d = PH_IDLE;
         default:  phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else        phase_q <= phase_d;
   end
endmodule

// File: rtl/mgr_chk.sv
module mgr_chk #(
   parameter int DATA_W = 16,
   parameter int N_SRC  = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 issue_i,
   input logic                 busy_o,
   input logic [N_SRC-1:0]     rd_rel_o,
   input logic [N_SRC-1:0]     rd_go_i,
   input logic                 wr_rel_o,
   input logic                 wr_go_i,
   input logic [DATA_W-1:0]    result_o
);
   logic [N_SRC-1:0] seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= '0;
      else if (issue_i && !busy_o) seen_q <= '0;
      else seen_q <= seen_q | (rd_rel_o & rd_go_i);
   end

   p_busy_after_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && !busy_o) |=> busy_o);

   p_busy_needs_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(issue_i));

   for (genvar gi = 0; gi < N_SRC; gi++) begin : g_rd
      p_rel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_rel_o[gi] && !rd_go_i[gi]) |=> rd_rel_o[gi]);

      p_rel_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
         rd_rel_o[gi] |-> busy_o);

      p_rel_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_rel_o[gi] && rd_go_i[gi]) |=> !rd_rel_o[gi]);

      p_rel_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
         seen_q[gi] |-> !rd_rel_o[gi]);
   end

   p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_rel_o && !wr_go_i) |=> (wr_rel_o && $stable(result_o)));

   p_wr_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_rel_o && wr_go_i) |=> !busy_o);
endmodule

bind alu_opnd_mgr mgr_chk #(.DATA_W(DATA_W), .N_SRC(N_SRC)) u_chk (.*);

// File: tb/tb_alu_opnd_mgr.sv
module tb_alu_opnd_mgr;
   localparam int DW = 16;

   typedef struct packed {
      logic [3:0]  op;
      logic        inv;
      logic        zero;
      logic        immok;
      logic [15:0] imm;
      logic [1:0]  mask;
      logic [15:0] a;
      logic [15:0] b;
      logic [3:0]  da;
      logic [3:0]  db;
      logic [15:0] exp;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{4'd1, 1'b0, 1'b0, 1'b0, 16'd0, 2'b00, 16'd5,      16'd2, 4'd0, 4'd3, 16'd7},
      '{4'd1, 1'b0, 1'b0, 1'b1, 16'd8, 2'b00, 16'd5,      16'd2, 4'd2, 4'd0, 16'd13},
      '{4'd1, 1'b1, 1'b0, 1'b0, 16'd0, 2'b00, 16'd5,      16'd2, 4'd1, 4'd1, 16'd65532},
      '{4'd1, 1'b0, 1'b1, 1'b1, 16'd8, 2'b00, 16'd5,      16'd2, 4'd0, 4'd0, 16'd8},
      '{4'd1, 1'b0, 1'b1, 1'b0, 16'd0, 2'b00, 16'd5,      16'd2, 4'd0, 4'd5, 16'd2},
      '{4'd0, 1'b0, 1'b0, 1'b0, 16'd0, 2'b00, 16'd5,      16'd2, 4'd4, 4'd0, 16'd3},
      '{4'd0, 1'b0, 1'b0, 1'b0, 16'd0, 2'b10, 16'd5,      16'd2, 4'd0, 4'd0, 16'd5},
      '{4'd1, 1'b0, 1'b0, 1'b0, 16'd0, 2'b01, 16'd5,      16'd9, 4'd0, 4'd2, 16'd9},
      '{4'd3, 1'b1, 1'b1, 1'b0, 16'd0, 2'b00, 16'd7,      16'd1, 4'd0, 4'd1, 16'hFFFE},
      '{4'd1, 1'b0, 1'b0, 1'b0, 16'd0, 2'b00, 16'hFFFF,   16'd2, 4'd2, 4'd2, 16'd1}
   };

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 issue_i = 1'b0;
   logic [3:0]           op_i = '0;
   logic                 inv_a_i = 1'b0, zero_a_i = 1'b0, imm_ok_i = 1'b0;
   logic [DW-1:0]        imm_i = '0;
   logic [1:0]           rd_mask_i = '0;
   logic [1:0]           rd_rel_o;
   logic [1:0]           rd_go_i = '0;
   logic [1:0][DW-1:0]   src_i = '0;
   logic [1:0][DW-1:0]   alu_opnd_o;
   logic                 busy_o, wr_rel_o;
   logic                 wr_go_i = 1'b0;
   logic [DW-1:0]        result_o;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit done  = 0;

   always #5 clk = ~clk;

   alu_opnd_mgr dut (
      .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i),
      .inv_a_i(inv_a_i), .zero_a_i(zero_a_i), .imm_ok_i(imm_ok_i),
      .imm_i(imm_i), .rd_mask_i(rd_mask_i), .rd_rel_o(rd_rel_o),
      .rd_go_i(rd_go_i), .src_i(src_i), .alu_opnd_o(alu_opnd_o),
      .busy_o(busy_o), .wr_rel_o(wr_rel_o), .wr_go_i(wr_go_i),
      .result_o(result_o)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_vec(input vec_t v, input bit poke);
      logic [1:0]    need;
      logic [DW-1:0] opa;
      logic [DW-1:0] opb;
      int            waited;
      need[0] = !(v.mask[0] || v.zero);
      need[1] = !(v.mask[1] || v.immok);
      opa = (v.zero || v.mask[0]) ? '0 : v.a;
      if (v.inv) opa = ~opa;
      opb = v.immok ? v.imm : (v.mask[1] ? '0 : v.b);

      @(negedge clk);
      issue_i = 1'b1; op_i = v.op; inv_a_i = v.inv; zero_a_i = v.zero;
      imm_ok_i = v.immok; imm_i = v.imm; rd_mask_i = v.mask;
      #1 chk(busy_o == 1'b0, "R2 busy low at issue", busy_o, 0);
      @(negedge clk);
      issue_i = 1'b0; op_i = 4'd2; inv_a_i = ~v.inv; zero_a_i = ~v.zero;
      imm_ok_i = ~v.immok; imm_i = 16'h5A5A;
      #1 chk(busy_o == 1'b1, "R2 busy after issue", busy_o, 1);
      chk(rd_rel_o == need, "R3 R6 R7 R8 release set", rd_rel_o, need);
      if (poke) begin
         issue_i = 1'b1; op_i = 4'd0;
         @(negedge clk);
         issue_i = 1'b0;
         #1 chk(rd_rel_o == need, "R13 issue while busy", rd_rel_o, need);
      end
      if (need[0]) begin
         for (int k = 0; k < int'(v.da); k++) begin
            @(negedge clk);
            #1 chk(rd_rel_o[0] == 1'b1, "R3 release A held", rd_rel_o[0], 1);
         end
         rd_go_i[0] = 1'b1; src_i[0] = v.a;
         #1 chk(alu_opnd_o[0] == opa, "R4 R9 operand A forwarded", alu_opnd_o[0], opa);
         @(negedge clk);
         rd_go_i[0] = 1'b0; src_i[0] = 16'hDEAD;
         #1 chk(rd_rel_o[0] == 1'b0, "R5 release A drops", rd_rel_o[0], 0);
      end
      if (need[1]) begin
         for (int k = 0; k < int'(v.db); k++) begin
            @(negedge clk);
            #1 chk(rd_rel_o[1] == 1'b1, "R3 release B held", rd_rel_o[1], 1);
         end
         rd_go_i[1] = 1'b1; src_i[1] = v.b;
         #1 chk(alu_opnd_o[1] == opb, "R4 operand B forwarded", alu_opnd_o[1], opb);
         @(negedge clk);
         rd_go_i[1] = 1'b0; src_i[1] = 16'hBEEF;
         #1 chk(rd_rel_o[1] == 1'b0, "R5 release B drops", rd_rel_o[1], 0);
      end
      waited = 0;
      while (!wr_rel_o && waited < 50) begin
         @(negedge clk);
         #1 waited++;
      end
      chk(wr_rel_o == 1'b1, "R10 write release", wr_rel_o, 1);
      chk(result_o == v.exp, "R11 R12 result", result_o, v.exp);
      @(negedge clk);
      #1 chk(wr_rel_o && result_o == v.exp, "R10 result held", result_o, v.exp);
      chk(rd_rel_o == 2'b00, "R5 no re-release", rd_rel_o, 0);
      wr_go_i = 1'b1;
      @(negedge clk);
      wr_go_i = 1'b0;
      #1 chk(busy_o == 1'b0, "R10 busy ends after write", busy_o, 0);
      chk(wr_rel_o == 1'b0, "R10 write release drops", wr_rel_o, 0);
      rd_mask_i = '0; op_i = '0; inv_a_i = 0; zero_a_i = 0; imm_ok_i = 0;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000 && !done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #1;
      chk(busy_o == 0 && rd_rel_o == 0 && wr_rel_o == 0, "R1 in reset",
          {busy_o, rd_rel_o, wr_rel_o}, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1 chk(busy_o == 0 && rd_rel_o == 0 && wr_rel_o == 0, "R1 after reset",
             {busy_o, rd_rel_o, wr_rel_o}, 0);

      for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

      // R13: stray issue during busy leaves the add of 5 and 2 intact
      run_vec(VECS[0], 1'b1);

      // R2: idle without issue, busy stays low
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         #1 chk(busy_o == 1'b0, "R2 no spontaneous busy", busy_o, 0);
      end

      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule